// File: doc/BRIEF.md
# Associative TLB Permission Lookup

This block is the translation buffer of an embedded processor core. It keeps a small set of fully associative entries, each mapping one virtual page of a programmable size to a real page, tagged with a process ID, an address-space bit and two permission nibbles: one for user mode and one for supervisor mode. A lookup request supplies the following:

- the virtual address;
- whether the access is an instruction fetch or a data access;
- for data, whether it is a read or a write;
- the current process ID;
- the privilege level;
- the two address-space selectors, one for fetch and one for data.

The block walks the entries one per clock in index order. An entry that matches on address and process ID but lives in the other address space is skipped. An entry that matches but denies the access does not stop the walk: the fault kind is remembered and later entries are still tried. The first entry that grants the access ends the walk at once.

The result is a two-bit status, a real address that is meaningful only on success, and the permission nibble of the last entry that passed the address-space test. The result is presented for exactly one cycle with a done pulse, and it stays on the outputs until the next lookup completes. Entries are loaded one at a time through a write port that is closed while a walk is running. All entries can be invalidated at once with a single pulse.

Top module: `tlb_perm_lookup`

## Requirements
- R1: The walk visits entries in ascending index order, one per clock. The first entry that grants the access ends the walk. For a grant at index i, lk_done is high in the (i+1)-th cycle after the cycle in which lk_start was accepted.
- R2: When no entry grants and none passed the address-space test, lk_status is 1 (miss) and lk_perm is 0. This result appears N_ENTRIES cycles after the start.
- R3: An entry takes part only if all of the following hold:
  - it is valid;
  - `((vaddr ^ epn) & ~mask) == 0`, where a mask bit of 1 marks a page-offset bit;
  - its tag is 0 (which matches any process ID) or equals lk_pid.
- R4: An entry that matches per R3 is skipped unless its address-space bit equals lk_fetch_as (for a fetch) or lk_data_as (for a data access).
- R5: The permission byte is split into two nibbles. User mode (lk_user=1) uses bits [3:0] and supervisor mode uses bits [7:4]. Within a nibble, bit 0 is read, bit 1 is write, bit 2 is execute, and bit 3 is unused.
- R6: A fetch is granted only by the execute bit. A matching entry without it sets the pending status to 3 (execute denied), and the walk goes on.
- R7: A data read needs the read bit and a data write needs the write bit. A matching entry that denies sets the pending status to 2 (data denied), and the walk goes on. A later granting entry still yields status 0.
- R8: lk_perm reports the nibble of the last entry that passed R4, even when the lookup fails. On success, lk_raddr is `(rpn & ~mask) | (vaddr & mask)`; on any failure it is 0.
- R9: lk_done is a one-cycle pulse. lk_busy is high from the cycle after an accepted start until the done cycle, in which it is low. A start raised while busy is ignored. Request inputs are sampled only with an accepted start.
- R10: A write with wr_en high while lk_busy is low updates entry wr_idx in that cycle. A write while lk_busy is high is discarded.
- R11: Reset and inv_all both clear every valid bit. inv_all wins over a write in the same cycle. After reset, lk_done=0, lk_busy=0, lk_status=1, lk_raddr=0 and lk_perm=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_start | input | 1 | Start a lookup (accepted when not busy) |
| lk_vaddr | input | VA_W | Virtual address to translate |
| lk_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| lk_write | input | 1 | Data access is a write (ignored for fetch) |
| lk_pid | input | TID_W | Current process ID |
| lk_user | input | 1 | 1 = user mode, 0 = supervisor mode |
| lk_fetch_as | input | 1 | Address-space selector for fetches |
| lk_data_as | input | 1 | Address-space selector for data accesses |
| wr_en | input | 1 | Write one entry |
| wr_idx | input | IDX_W | Entry index to write |
| wr_valid | input | 1 | Valid bit to store |
| wr_epn | input | VA_W | Virtual page base |
| wr_mask | input | VA_W | Page-offset mask (1 = offset bit) |
| wr_tid | input | TID_W | Process tag, 0 = any |
| wr_rpn | input | VA_W | Real page base |
| wr_as | input | 1 | Address-space bit |
| wr_perm | input | 8 | Supervisor nibble [7:4], user nibble [3:0] |
| inv_all | input | 1 | Invalidate all entries |
| lk_busy | output | 1 | Walk in progress |
| lk_done | output | 1 | One-cycle result strobe |
| lk_status | output | 2 | 0 ok, 1 miss, 2 data denied, 3 execute denied |
| lk_raddr | output | VA_W | Real address (0 unless ok) |
| lk_perm | output | 4 | Nibble of last entry passing the space test |

## Verification
Lookups are run against a table in which several entries overlap the same page:

- A user write that hits a read-only entry before a writable one checks that a denial does not end the walk.
- A fetch that finds only a non-executable entry checks that the pending execute fault and its nibble survive to the end.
- Process-ID and address-space mismatches are shown to skip entries rather than fault on them.
- Pages of two sizes check the real-address splice.
- Writes and starts issued during a walk, and an invalidate followed by a lookup, check that the table and the running request are left alone.

The reference model predicts both the completion cycle and the result of every lookup, so a wrong walk order shows up as a timing mismatch even when the result is right.

// File: rtl/tlb_pkg.sv
// Package: shared types for the TLB permission lookup.
// Assumes: status encoding is fixed and visible at the top-level ports.
package tlb_pkg;

    // Lookup result codes (R2, R6, R7)
    typedef enum logic [1:0] {
        ST_OK        = 2'd0,
        ST_MISS      = 2'd1,
        ST_DATA_DENY = 2'd2,
        ST_EXEC_DENY = 2'd3
    } lk_status_e;

    // Walk controller states
    typedef enum logic {
        SC_IDLE = 1'b0,
        SC_SCAN = 1'b1
    } scan_state_e;

    // Bit positions inside a permission nibble (R5)
    localparam int PB_READ  = 0;
    localparam int PB_WRITE = 1;
    localparam int PB_EXEC  = 2;
    localparam int NIB_W    = 4;
    localparam int PBYTE_W  = 2 * NIB_W;

endpackage

// File: rtl/tlb_entry_store.sv
// Module: tlb_entry_store
// Holds the TLB entries and serves one entry per cycle to the walker.
// Assumes: writes are refused while busy; inv_all beats a same-cycle write;
// out-of-range write indices are dropped.
module tlb_entry_store
    import tlb_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    parameter int IDX_W     = 3,
    parameter int VA_W      = 32,
    parameter int TID_W     = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               busy,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic               wr_valid,
    input  logic [VA_W-1:0]    wr_epn,
    input  logic [VA_W-1:0]    wr_mask,
    input  logic [TID_W-1:0]   wr_tid,
    input  logic [VA_W-1:0]    wr_rpn,
    input  logic               wr_as,
    input  logic [PBYTE_W-1:0] wr_perm,
    input  logic               inv_all,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic               rd_vld,
    output logic [VA_W-1:0]    rd_epn,
    output logic [VA_W-1:0]    rd_mask,
    output logic [TID_W-1:0]   rd_tid,
    output logic [VA_W-1:0]    rd_rpn,
    output logic               rd_as,
    output logic [PBYTE_W-1:0] rd_perm
);

    logic [N_ENTRIES-1:0] vld_q;
    logic [VA_W-1:0]      epn_q  [N_ENTRIES];
    logic [VA_W-1:0]      mask_q [N_ENTRIES];
    logic [TID_W-1:0]     tid_q  [N_ENTRIES];
    logic [VA_W-1:0]      rpn_q  [N_ENTRIES];
    logic                 as_q   [N_ENTRIES];
    logic [PBYTE_W-1:0]   perm_q [N_ENTRIES];
    logic                 wr_go;

    // Accept a write only when idle and the index exists (R10)
    assign wr_go = wr_en && !busy && (int'(wr_idx) < N_ENTRIES);

    // Valid bits: reset and invalidate-all clear, accepted writes set (R10, R11)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            for (int i = 0; i < N_ENTRIES; i++) begin
                if (inv_all) begin
                    vld_q[i] <= 1'b0;
                end else if (wr_go && (int'(wr_idx) == i)) begin
                    vld_q[i] <= wr_valid;
                end
            end
        end
    end

    // Entry payload: written on an accepted write, never reset
    always_ff @(posedge clk) begin
        if (wr_go) begin
            epn_q[wr_idx]  <= wr_epn;
            mask_q[wr_idx] <= wr_mask;
            tid_q[wr_idx]  <= wr_tid;
            rpn_q[wr_idx]  <= wr_rpn;
            as_q[wr_idx]   <= wr_as;
            perm_q[wr_idx] <= wr_perm;
        end
    end

    // Read port: the entry currently under examination
    always_comb begin
        rd_vld  = vld_q[rd_idx];
        rd_epn  = epn_q[rd_idx];
        rd_mask = mask_q[rd_idx];
        rd_tid  = tid_q[rd_idx];
        rd_rpn  = rpn_q[rd_idx];
        rd_as   = as_q[rd_idx];
        rd_perm = perm_q[rd_idx];
    end

    // Invalidate-all leaves no valid entry behind (R11)
    assert_inv_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> (vld_q == '0));

    // A write during a walk changes no entry (R10)
    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_wr_guard
        assert_write_refused_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && busy && !inv_all) |=>
                ($stable(vld_q[g]) && $stable(epn_q[g]) && $stable(rpn_q[g]) &&
                 $stable(perm_q[g]) && $stable(mask_q[g])));
    end

endmodule

// File: rtl/tlb_entry_eval.sv
// Module: tlb_entry_eval
// Judges one entry against the latched request: address/tag match,
// address-space test, privilege nibble choice and permission grant.
// Assumes: purely combinational; the caller sequences the entries.
module tlb_entry_eval
    import tlb_pkg::*;
#(
    parameter int VA_W  = 32,
    parameter int TID_W = 8
) (
    input  logic               e_vld,
    input  logic [VA_W-1:0]    e_epn,
    input  logic [VA_W-1:0]    e_mask,
    input  logic [TID_W-1:0]   e_tid,
    input  logic [VA_W-1:0]    e_rpn,
    input  logic               e_as,
    input  logic [PBYTE_W-1:0] e_perm,
    input  logic [VA_W-1:0]    q_vaddr,
    input  logic [TID_W-1:0]   q_pid,
    input  logic               q_user,
    input  logic               q_fetch,
    input  logic               q_write,
    input  logic               q_fetch_as,
    input  logic               q_data_as,
    output logic               ev_space_ok,
    output logic               ev_grant,
    output logic [NIB_W-1:0]   ev_nib,
    output logic [VA_W-1:0]    ev_raddr
);

    logic addr_hit;
    logic tag_hit;
    logic want_as;
    int   need_bit;

    // Address and tag match (R3)
    always_comb begin
        addr_hit = (((q_vaddr ^ e_epn) & ~e_mask) == '0);
        tag_hit  = (e_tid == '0) || (e_tid == q_pid);
    end

    // Address-space test against the selector of this access kind (R4)
    always_comb begin
        want_as     = q_fetch ? q_fetch_as : q_data_as;
        ev_space_ok = e_vld && addr_hit && tag_hit && (e_as == want_as);
    end

    // Privilege nibble and the permission bit this access needs (R5, R6, R7)
    always_comb begin
        ev_nib = q_user ? e_perm[NIB_W-1:0] : e_perm[PBYTE_W-1:NIB_W];
        if (q_fetch) begin
            need_bit = PB_EXEC;
        end else if (q_write) begin
            need_bit = PB_WRITE;
        end else begin
            need_bit = PB_READ;
        end
        ev_grant = ev_space_ok && ev_nib[need_bit];
    end

    // Real address: page base above the mask, request offset below it (R8)
    assign ev_raddr = (e_rpn & ~e_mask) | (q_vaddr & e_mask);

endmodule

// File: rtl/tlb_scan_ctrl.sv
// Module: tlb_scan_ctrl
// Walks entries 0..N-1, one per clock, keeps the pending fault and the last
// space-passing nibble, and publishes the result with a one-cycle done.
// Assumes: request inputs matter only in the cycle a start is accepted.
module tlb_scan_ctrl
    import tlb_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    parameter int IDX_W     = 3,
    parameter int VA_W      = 32,
    parameter int TID_W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [VA_W-1:0]  in_vaddr,
    input  logic             in_fetch,
    input  logic             in_write,
    input  logic [TID_W-1:0] in_pid,
    input  logic             in_user,
    input  logic             in_fetch_as,
    input  logic             in_data_as,
    input  logic             ev_space_ok,
    input  logic             ev_grant,
    input  logic [NIB_W-1:0] ev_nib,
    input  logic [VA_W-1:0]  ev_raddr,
    output logic [IDX_W-1:0] rd_idx,
    output logic [VA_W-1:0]  q_vaddr,
    output logic             q_fetch,
    output logic             q_write,
    output logic [TID_W-1:0] q_pid,
    output logic             q_user,
    output logic             q_fetch_as,
    output logic             q_data_as,
    output logic             busy,
    output logic             done,
    output lk_status_e       status,
    output logic [VA_W-1:0]  raddr,
    output logic [NIB_W-1:0] perm
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_ENTRIES - 1);

    scan_state_e      state_q;
    logic [IDX_W-1:0] idx_q;
    lk_status_e       pend_status_q;
    logic [NIB_W-1:0] pend_perm_q;
    lk_status_e       deny_kind;

    assign busy   = (state_q == SC_SCAN);
    assign rd_idx = idx_q;

    // Fault kind a space-passing but denying entry would record (R6, R7)
    assign deny_kind = q_fetch ? ST_EXEC_DENY : ST_DATA_DENY;

    // Request latch: capture the request only on an accepted start (R9)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_vaddr    <= '0;
            q_fetch    <= 1'b0;
            q_write    <= 1'b0;
            q_pid      <= '0;
            q_user     <= 1'b0;
            q_fetch_as <= 1'b0;
            q_data_as  <= 1'b0;
        end else if (state_q == SC_IDLE && start) begin
            q_vaddr    <= in_vaddr;
            q_fetch    <= in_fetch;
            q_write    <= in_write;
            q_pid      <= in_pid;
            q_user     <= in_user;
            q_fetch_as <= in_fetch_as;
            q_data_as  <= in_data_as;
        end
    end

    // Walk sequencer: state, entry index and done strobe (R1, R2, R9)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SC_IDLE;
            idx_q   <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state_q)
                SC_IDLE: begin
                    if (start) begin
                        state_q <= SC_SCAN;
                        idx_q   <= '0;
                    end
                end
                SC_SCAN: begin
                    if (ev_grant || idx_q == LAST_IDX) begin
                        state_q <= SC_IDLE;
                        done    <= 1'b1;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: state_q <= SC_IDLE;
            endcase
        end
    end

    // Pending fault and nibble, rebuilt during each walk (R6, R7, R8)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_status_q <= ST_MISS;
            pend_perm_q   <= '0;
        end else if (state_q == SC_IDLE) begin
            if (start) begin
                pend_status_q <= ST_MISS;
                pend_perm_q   <= '0;
            end
        end else if (ev_space_ok) begin
            pend_perm_q <= ev_nib;
            if (!ev_grant) begin
                pend_status_q <= deny_kind;
            end
        end
    end

    // Published result: updated only at the end of a walk (R2, R8, R11)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= ST_MISS;
            raddr  <= '0;
            perm   <= '0;
        end else if (state_q == SC_SCAN) begin
            if (ev_grant) begin
                status <= ST_OK;
                raddr  <= ev_raddr;
                perm   <= ev_nib;
            end else if (idx_q == LAST_IDX) begin
                status <= ev_space_ok ? deny_kind : pend_status_q;
                raddr  <= '0;
                perm   <= ev_space_ok ? ev_nib : pend_perm_q;
            end
        end
    end

    // Done lasts one cycle (R9)
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // An accepted start makes the block busy (R9)
    assert_start_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // A granted fetch reports a nibble with execute set (R6)
    assert_fetch_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == ST_OK && q_fetch) |-> perm[PB_EXEC]);

    // A granted data access reports the bit it needed (R7)
    assert_data_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == ST_OK && !q_fetch) |->
            (q_write ? perm[PB_WRITE] : perm[PB_READ]));

    // A failed lookup drives no real address (R8)
    assert_fail_raddr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status != ST_OK) |-> (raddr == '0));

    // A plain miss saw no space-passing entry, so the nibble is zero (R2)
    assert_miss_perm_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == ST_MISS) |-> (perm == '0));

endmodule

// File: rtl/tlb_perm_lookup.sv
// Module: tlb_perm_lookup (top)
// Fully associative TLB with a sequential permission-checking walk.
// Connects the entry store, the single-entry evaluator and the walker.
// Assumes: synchronous active-low reset; N_ENTRIES >= 2.
module tlb_perm_lookup
    import tlb_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    parameter int VA_W      = 32,
    parameter int TID_W     = 8,
    parameter int IDX_W     = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_start,
    input  logic [VA_W-1:0]  lk_vaddr,
    input  logic             lk_fetch,
    input  logic             lk_write,
    input  logic [TID_W-1:0] lk_pid,
    input  logic             lk_user,
    input  logic             lk_fetch_as,
    input  logic             lk_data_as,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_valid,
    input  logic [VA_W-1:0]  wr_epn,
    input  logic [VA_W-1:0]  wr_mask,
    input  logic [TID_W-1:0] wr_tid,
    input  logic [VA_W-1:0]  wr_rpn,
    input  logic             wr_as,
    input  logic [7:0]       wr_perm,
    input  logic             inv_all,
    output logic             lk_busy,
    output logic             lk_done,
    output logic [1:0]       lk_status,
    output logic [VA_W-1:0]  lk_raddr,
    output logic [3:0]       lk_perm
);

    logic [IDX_W-1:0]   rd_idx;
    logic               rd_vld;
    logic [VA_W-1:0]    rd_epn;
    logic [VA_W-1:0]    rd_mask;
    logic [TID_W-1:0]   rd_tid;
    logic [VA_W-1:0]    rd_rpn;
    logic               rd_as;
    logic [PBYTE_W-1:0] rd_perm;

    logic [VA_W-1:0]    q_vaddr;
    logic               q_fetch;
    logic               q_write;
    logic [TID_W-1:0]   q_pid;
    logic               q_user;
    logic               q_fetch_as;
    logic               q_data_as;

    logic               ev_space_ok;
    logic               ev_grant;
    logic [NIB_W-1:0]   ev_nib;
    logic [VA_W-1:0]    ev_raddr;
    lk_status_e         status;

    assign lk_status = status;

    // Entry storage with write and invalidate ports
    tlb_entry_store #(
        .N_ENTRIES (N_ENTRIES),
        .IDX_W     (IDX_W),
        .VA_W      (VA_W),
        .TID_W     (TID_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy     (lk_busy),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_valid (wr_valid),
        .wr_epn   (wr_epn),
        .wr_mask  (wr_mask),
        .wr_tid   (wr_tid),
        .wr_rpn   (wr_rpn),
        .wr_as    (wr_as),
        .wr_perm  (wr_perm),
        .inv_all  (inv_all),
        .rd_idx   (rd_idx),
        .rd_vld   (rd_vld),
        .rd_epn   (rd_epn),
        .rd_mask  (rd_mask),
        .rd_tid   (rd_tid),
        .rd_rpn   (rd_rpn),
        .rd_as    (rd_as),
        .rd_perm  (rd_perm)
    );

    // Judgement of the entry under examination
    tlb_entry_eval #(
        .VA_W  (VA_W),
        .TID_W (TID_W)
    ) u_eval (
        .e_vld       (rd_vld),
        .e_epn       (rd_epn),
        .e_mask      (rd_mask),
        .e_tid       (rd_tid),
        .e_rpn       (rd_rpn),
        .e_as        (rd_as),
        .e_perm      (rd_perm),
        .q_vaddr     (q_vaddr),
        .q_pid       (q_pid),
        .q_user      (q_user),
        .q_fetch     (q_fetch),
        .q_write     (q_write),
        .q_fetch_as  (q_fetch_as),
        .q_data_as   (q_data_as),
        .ev_space_ok (ev_space_ok),
        .ev_grant    (ev_grant),
        .ev_nib      (ev_nib),
        .ev_raddr    (ev_raddr)
    );

    // Walk controller and result registers
    tlb_scan_ctrl #(
        .N_ENTRIES (N_ENTRIES),
        .IDX_W     (IDX_W),
        .VA_W      (VA_W),
        .TID_W     (TID_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (lk_start),
        .in_vaddr    (lk_vaddr),
        .in_fetch    (lk_fetch),
        .in_write    (lk_write),
        .in_pid      (lk_pid),
        .in_user     (lk_user),
        .in_fetch_as (lk_fetch_as),
        .in_data_as  (lk_data_as),
        .ev_space_ok (ev_space_ok),
        .ev_grant    (ev_grant),
        .ev_nib      (ev_nib),
        .ev_raddr    (ev_raddr),
        .rd_idx      (rd_idx),
        .q_vaddr     (q_vaddr),
        .q_fetch     (q_fetch),
        .q_write     (q_write),
        .q_pid       (q_pid),
        .q_user      (q_user),
        .q_fetch_as  (q_fetch_as),
        .q_data_as   (q_data_as),
        .busy        (lk_busy),
        .done        (lk_done),
        .status      (status),
        .raddr       (lk_raddr),
        .perm        (lk_perm)
    );

endmodule

// File: tb/tlb_perm_lookup_bench.sv
// Bench for tlb_perm_lookup: a behavioural model of the table and the walk
// timing, compared with the outputs on every falling edge.
module tlb_perm_lookup_bench;

    localparam int N  = 8;
    localparam int VW = 32;
    localparam int TW = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lk_start = 1'b0;
    logic [VW-1:0] lk_vaddr = '0;
    logic          lk_fetch = 1'b0;
    logic          lk_write = 1'b0;
    logic [TW-1:0] lk_pid = '0;
    logic          lk_user = 1'b0;
    logic          lk_fetch_as = 1'b0;
    logic          lk_data_as = 1'b0;
    logic          wr_en = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic          wr_valid = 1'b0;
    logic [VW-1:0] wr_epn = '0;
    logic [VW-1:0] wr_mask = '0;
    logic [TW-1:0] wr_tid = '0;
    logic [VW-1:0] wr_rpn = '0;
    logic          wr_as = 1'b0;
    logic [7:0]    wr_perm = '0;
    logic          inv_all = 1'b0;
    logic          lk_busy;
    logic          lk_done;
    logic [1:0]    lk_status;
    logic [VW-1:0] lk_raddr;
    logic [3:0]    lk_perm;

    always #2 clk = ~clk;  // 250 MHz

    tlb_perm_lookup #(.N_ENTRIES(N), .VA_W(VW), .TID_W(TW)) u_tlb_perm_lookup (
        .clk(clk), .rst_n(rst_n), .lk_start(lk_start), .lk_vaddr(lk_vaddr),
        .lk_fetch(lk_fetch), .lk_write(lk_write), .lk_pid(lk_pid), .lk_user(lk_user),
        .lk_fetch_as(lk_fetch_as), .lk_data_as(lk_data_as), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_valid(wr_valid), .wr_epn(wr_epn), .wr_mask(wr_mask),
        .wr_tid(wr_tid), .wr_rpn(wr_rpn), .wr_as(wr_as), .wr_perm(wr_perm),
        .inv_all(inv_all), .lk_busy(lk_busy), .lk_done(lk_done),
        .lk_status(lk_status), .lk_raddr(lk_raddr), .lk_perm(lk_perm));

    int n_checks = 0;
    int n_err = 0;
    int cyc = 0;
    string cur_tag = "R11";

    // Reference table and walk state
    logic          m_vld [N];
    logic [VW-1:0] m_epn [N];
    logic [VW-1:0] m_mask [N];
    logic [TW-1:0] m_tid [N];
    logic [VW-1:0] m_rpn [N];
    logic          m_as [N];
    logic [7:0]    m_perm [N];
    logic          m_busy = 1'b0;
    logic          m_done = 1'b0;
    int            m_cnt = 0;
    logic [1:0]    m_status = 2'd1, p_status;
    logic [VW-1:0] m_raddr = '0, p_raddr;
    logic [3:0]    m_perm_o = '0, p_perm;
    int            p_cnt;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // Result of a lookup from the requirements, walking entries in order
    task automatic model_eval();
        logic [3:0] nib;
        logic want, found;
        p_status = 2'd1; p_raddr = '0; p_perm = '0; p_cnt = N; found = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (!found && m_vld[i] && (((lk_vaddr ^ m_epn[i]) & ~m_mask[i]) == '0) &&
                (m_tid[i] == '0 || m_tid[i] == lk_pid)) begin
                want = lk_fetch ? lk_fetch_as : lk_data_as;
                if (m_as[i] == want) begin
                    nib = lk_user ? m_perm[i][3:0] : m_perm[i][7:4];
                    p_perm = nib;
                    if (lk_fetch ? nib[2] : (lk_write ? nib[1] : nib[0])) begin
                        p_status = 2'd0;
                        p_raddr = (m_rpn[i] & ~m_mask[i]) | (lk_vaddr & m_mask[i]);
                        p_cnt = i + 1;
                        found = 1'b1;
                    end else begin
                        p_status = lk_fetch ? 2'd3 : 2'd2;
                    end
                end
            end
        end
    endtask

    // Model update on the active edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) m_vld[i] = 1'b0;
            m_busy = 1'b0; m_done = 1'b0; m_cnt = 0;
            m_status = 2'd1; m_raddr = '0; m_perm_o = '0;
        end else begin
            m_done = 1'b0;
            if (wr_en && !m_busy) begin
                m_vld[wr_idx] = wr_valid; m_epn[wr_idx] = wr_epn;
                m_mask[wr_idx] = wr_mask; m_tid[wr_idx] = wr_tid;
                m_rpn[wr_idx] = wr_rpn; m_as[wr_idx] = wr_as; m_perm[wr_idx] = wr_perm;
            end
            if (inv_all) for (int i = 0; i < N; i++) m_vld[i] = 1'b0;
            if (m_busy) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    m_busy = 1'b0; m_done = 1'b1;
                    m_status = p_status; m_raddr = p_raddr; m_perm_o = p_perm;
                end
            end else if (lk_start) begin
                model_eval();
                m_cnt = p_cnt;
                m_busy = 1'b1;
            end
        end
    end

    // Compare every cycle away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(lk_done === m_done, "R9 done", 32'(lk_done), 32'(m_done));
            chk(lk_busy === m_busy, "R9 busy", 32'(lk_busy), 32'(m_busy));
            if (m_done) begin
                chk(lk_status === m_status, {cur_tag, " status"}, 32'(lk_status), 32'(m_status));
                chk(lk_raddr === m_raddr, {cur_tag, " R8 raddr"}, lk_raddr, m_raddr);
                chk(lk_perm === m_perm_o, {cur_tag, " R8 perm"}, 32'(lk_perm), 32'(m_perm_o));
            end
        end
    end

    // Watchdog: a hung run counts as a failure
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_err++;
            $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    task automatic put(input int idx, input logic v, input logic [31:0] epn,
                       input logic [31:0] mask, input logic [7:0] tid,
                       input logic [31:0] rpn, input logic as_b, input logic [7:0] pb);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = IW'(idx); wr_valid = v; wr_epn = epn; wr_mask = mask;
        wr_tid = tid; wr_rpn = rpn; wr_as = as_b; wr_perm = pb;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic req(input logic [31:0] va, input logic f, input logic w,
                       input logic [7:0] pid, input logic u, input logic fas,
                       input logic das);
        lk_vaddr = va; lk_fetch = f; lk_write = w; lk_pid = pid;
        lk_user = u; lk_fetch_as = fas; lk_data_as = das;
    endtask

    task automatic look(input string tag, input logic [31:0] va, input logic f,
                        input logic w, input logic [7:0] pid, input logic u,
                        input logic fas, input logic das);
        @(negedge clk);
        cur_tag = tag;
        req(va, f, w, pid, u, fas, das);
        lk_start = 1'b1;
        @(negedge clk);
        lk_start = 1'b0;
        req('0, 1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b0);
        while (!m_done) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state at the ports
        chk(lk_status == 2'd1 && lk_raddr == '0 && lk_perm == '0, "R11 reset outputs",
            {lk_status, lk_perm, lk_raddr[25:0]}, {2'd1, 4'd0, 26'd0});
        look("R2 R11 empty", 32'h1000_0abc, 1'b0, 1'b0, 8'd5, 1'b1, 1'b0, 1'b0);

        put(0, 1, 32'h1000_0000, 32'h0000_0fff, 8'd5, 32'h8000_0000, 0, 8'h73);
        put(1, 1, 32'h1000_0000, 32'h0000_0fff, 8'd0, 32'h8100_0000, 1, 8'h44);
        put(2, 1, 32'h2000_0000, 32'h0000_ffff, 8'd0, 32'h8200_0000, 0, 8'h01);
        put(3, 1, 32'h2000_0000, 32'h0000_ffff, 8'd0, 32'h9000_0000, 0, 8'h02);
        put(5, 1, 32'h3000_0000, 32'h0000_0fff, 8'd9, 32'ha000_0000, 0, 8'h00);

        look("R1 R5 user read", 32'h1000_0abc, 0, 0, 8'd5, 1, 0, 0);
        look("R3 R4 tag skip", 32'h1000_0abc, 0, 0, 8'd6, 1, 0, 0);
        look("R4 R6 fetch other space", 32'h1000_0010, 1, 0, 8'd6, 1, 1, 0);
        look("R6 R8 exec denied", 32'h1000_0010, 1, 0, 8'd5, 1, 0, 0);
        look("R5 R6 supervisor fetch", 32'h1000_0010, 1, 0, 8'd5, 0, 0, 0);
        look("R7 R1 deny then grant", 32'h2000_1234, 0, 1, 8'd77, 1, 0, 0);
        look("R7 user read 64K", 32'h2000_fff0, 0, 0, 8'd1, 1, 0, 0);
        look("R7 data denied", 32'h3000_0010, 0, 1, 8'd9, 0, 0, 0);
        look("R3 tag mismatch", 32'h3000_0010, 0, 1, 8'd8, 0, 0, 0);

        // R10: write during a walk is discarded
        @(negedge clk);
        cur_tag = "R10 refused";
        req(32'h5000_0040, 0, 0, 8'd1, 1, 0, 0);
        lk_start = 1'b1;
        @(negedge clk);
        lk_start = 1'b0;
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'd6; wr_valid = 1'b1; wr_epn = 32'h5000_0000;
        wr_mask = 32'h0000_0fff; wr_tid = 8'd0; wr_rpn = 32'hb000_0000;
        wr_as = 1'b0; wr_perm = 8'h11;
        @(negedge clk);
        wr_en = 1'b0;
        while (!m_done) @(negedge clk);
        look("R10 still missing", 32'h5000_0040, 0, 0, 8'd1, 1, 0, 0);
        put(6, 1, 32'h5000_0000, 32'h0000_0fff, 8'd0, 32'hb000_0000, 0, 8'h11);
        look("R10 idle write hits", 32'h5000_0040, 0, 0, 8'd1, 1, 0, 0);

        // R9: a second start during the walk is ignored
        @(negedge clk);
        cur_tag = "R9 start ignored";
        req(32'h7000_0000, 0, 0, 8'd1, 1, 0, 0);
        lk_start = 1'b1;
        @(negedge clk);
        req(32'h5000_0040, 0, 0, 8'd1, 1, 0, 0);
        @(negedge clk);
        lk_start = 1'b0;
        while (!m_done) @(negedge clk);

        // R11: invalidate-all beats a same-cycle write
        @(negedge clk);
        inv_all = 1'b1;
        wr_en = 1'b1; wr_idx = 3'd7; wr_valid = 1'b1; wr_epn = 32'h6000_0000;
        wr_mask = 32'h0000_0fff; wr_tid = 8'd0; wr_rpn = 32'hc000_0000;
        wr_as = 1'b0; wr_perm = 8'h77;
        @(negedge clk);
        inv_all = 1'b0; wr_en = 1'b0;
        look("R11 inv old entry", 32'h1000_0abc, 0, 0, 8'd5, 1, 0, 0);
        look("R11 inv beats write", 32'h6000_0000, 0, 0, 8'd5, 1, 0, 0);

        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule